// File: doc/BRIEF.md
# Local Interrupt-Controller Countdown Timer

This block is a 32-bit down-counter of the kind found beside a processor's local interrupt controller. Software programs it through a small register port. It has a vector-table entry that sets the interrupt vector, a mask and a counting mode. It also has an initial-count register, a read-only current-count register and a divide-configuration register. The divide setting feeds a prescaler that turns the bus clock into count ticks.

Writing a non-zero initial count loads the current count and starts the countdown. Each prescaled tick takes one off the count. When the count runs out, one-shot mode stops at zero, and periodic mode reloads the initial count and keeps going. In either mode the block raises a one-cycle interrupt request that carries the programmed vector, unless the mask is set. Writing zero to the initial count stops the timer. The deadline mode code is accepted and stored, but it holds the counter frozen.

Top module: `loc_irq_timer`

## Requirements
- R1: After reset, the entry register (offset 0x320) reads 0x0001_0000 (mask set, everything else zero). The initial count (0x380), current count (0x390) and divide register (0x3E0) read zero, and irq_req is low.
- R2: Reads are combinational from reg_addr. The entry register keeps only the vector in bits 7:0, the mask in bit 16 and the mode in bits 18:17, and its other bits read zero. The divide register keeps bits 3:0. The initial count reads back as written. Any unmapped offset reads zero.
- R3: The divide code selects the divisor from bits {3,1,0}, and bit 2 is ignored. 0x0 gives 2, 0x1 gives 4, 0x2 gives 8, 0x3 gives 16, 0x8 gives 32, 0x9 gives 64, 0xA gives 128 and 0xB gives 1.
- R4: A write of a non-zero value N to the initial count loads the current count with N at that clock edge and restarts the prescaler. With divisor D and a counting mode, the current count k edges later is N - floor(k/D) until expiry.
- R5: In one-shot mode (mode 0), the decrement from 1 leaves the count at 0, where it stays. irq_req is high for exactly the one cycle after that edge, which comes N*D edges after the load.
- R6: In periodic mode (mode 1), the tick that would reach zero reloads the initial count instead. A one-cycle irq_req follows every N*D edges, so after k edges the count is N - ((floor(k/D)) mod N).
- R7: With the mask bit set, expiry raises no irq_req, but counting and periodic reloading go on unchanged.
- R8: Writing zero to the initial count forces the current count to zero, stops the countdown and prevents any later request.
- R9: The counter is a full 32 bits wide, and an initial count of 0xFFFF_FFFF loads and counts down from that value.
- R10: A write to the divide register restarts the prescaler phase, and no decrement happens on that edge. The next decrement comes a full new divisor period later.
- R11: A write to the current-count offset changes nothing. The count goes on as if the write had not happened.
- R12: Mode codes 2 (deadline) and 3 hold the current count frozen and never raise a request.
- R13: irq_vector always presents the vector field of the entry register, including while irq_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_req | output | 1 | One-cycle interrupt request on unmasked expiry |
| irq_vector | output | 8 | Vector field of the entry register |

## Verification
Register reads are due in the same cycle that reg_addr is set. A write takes effect at the rising edge that samples it. The current count drops at every D-th edge counted from the load or from a divide write. irq_req is high only in the cycle after the edge on which the count expires. The bench drives every input at a falling edge and samples 1 ns later, so the elapsed edge count since each write is known exactly. Expected counts and request totals are closed-form functions of N, D and that edge count. Requests are tallied at each rising edge, and the level in the current cycle is added when a result is sampled.

// File: rtl/lit_pkg.sv
package lit_pkg;

  localparam int unsigned OFS_ENTRY = 'h320;
  localparam int unsigned OFS_INIT  = 'h380;
  localparam int unsigned OFS_CUR   = 'h390;
  localparam int unsigned OFS_DIV   = 'h3E0;

  localparam int unsigned MASK_BIT  = 16;
  localparam int unsigned MODE_LSB  = 17;
  localparam int unsigned DIV_W     = 4;
  localparam int unsigned SH_W      = 3;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_DEADLINE = 2'd2,
    MODE_RSVD     = 2'd3
  } tmr_mode_e;

  // divisor = 2**shift; code bits {3,1,0} plus one, wrapping at 8
  function automatic logic [SH_W-1:0] div_shift(input logic [DIV_W-1:0] code);
    logic [SH_W-1:0] sel;
    sel = {code[3], code[1], code[0]};
    return sel + 3'd1;
  endfunction

endpackage

// File: rtl/lit_rst_sync.sv
module lit_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/lit_prescale.sv
module lit_prescale
  import lit_pkg::*;
#(
  parameter int unsigned PW = (1 << SH_W) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [SH_W-1:0] shift,
  output logic            tick
);

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] pcnt_d;
  logic [PW-1:0] last;

  always_comb begin
    last   = ~({PW{1'b1}} << shift);
    tick   = !clr && (pcnt_q == last);
    pcnt_d = (clr || tick) ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
    end
  end

  // R3: with a divisor above one, ticks never come back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && shift != '0 && !clr && $stable(shift)) |=> !tick);

  // R10: a phase restart is followed by a tick only when the divisor is one
  a_r10_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && $stable(shift)) |=> (!tick || shift == '0));

endmodule

// File: rtl/lit_counter.sv
module lit_counter
  import lit_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] reload_val,
  input  tmr_mode_e     mode,
  input  logic          mask,
  input  logic          tick,
  output logic [CW-1:0] cur,
  output logic          irq
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cur_q;
  logic [CW-1:0] cur_d;
  logic          cur_en;
  logic          counting;
  logic          fire;
  logic          irq_q;
  logic          irq_d;

  always_comb begin
    counting = (cur_q != '0) && (mode == MODE_ONESHOT || mode == MODE_PERIODIC);
    cur_d    = cur_q;
    cur_en   = 1'b0;
    fire     = 1'b0;
    if (load) begin
      cur_en = 1'b1;
      cur_d  = load_val;
    end else if (tick && counting) begin
      cur_en = 1'b1;
      if (cur_q == ONE) begin
        fire  = 1'b1;
        cur_d = (mode == MODE_PERIODIC) ? reload_val : '0;
      end else begin
        cur_d = cur_q - ONE;
      end
    end
    irq_d = fire && !mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (cur_en) begin
      cur_q <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign cur = cur_q;
  assign irq = irq_q;

  // R4: a load places the written value in the count
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur_q == $past(load_val));

  // R5: one-shot count stays at zero until reloaded
  a_r5_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ONESHOT && cur_q == '0 && !load) |=> cur_q == '0);

  // R6: periodic expiry reloads the initial count
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PERIODIC && tick && cur_q == ONE && !load) |=> cur_q == $past(reload_val));

  // R12: non-counting modes freeze the count
  a_r12_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_ONESHOT && mode != MODE_PERIODIC && !load) |=> $stable(cur_q));

endmodule

// File: rtl/lit_regs.sv
module lit_regs
  import lit_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned CW = 32,
  parameter int unsigned VW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [CW-1:0]   wdata,
  input  logic [CW-1:0]   cur,
  output logic [CW-1:0]   rdata,
  output logic [VW-1:0]   vec,
  output logic            mask,
  output tmr_mode_e       mode,
  output logic [CW-1:0]   init,
  output logic [SH_W-1:0] shift,
  output logic            load,
  output logic            div_wr
);

  localparam logic [AW-1:0] A_ENTRY = AW'(OFS_ENTRY);
  localparam logic [AW-1:0] A_INIT  = AW'(OFS_INIT);
  localparam logic [AW-1:0] A_CUR   = AW'(OFS_CUR);
  localparam logic [AW-1:0] A_DIV   = AW'(OFS_DIV);

  logic [VW-1:0]    vec_q;
  logic             mask_q;
  tmr_mode_e        mode_q;
  logic [CW-1:0]    init_q;
  logic [DIV_W-1:0] div_q;
  logic             entry_wr;

  always_comb begin
    entry_wr = wr && (addr == A_ENTRY);
    load     = wr && (addr == A_INIT);
    div_wr   = wr && (addr == A_DIV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      mask_q <= 1'b1;
      mode_q <= MODE_ONESHOT;
    end else if (entry_wr) begin
      vec_q  <= wdata[VW-1:0];
      mask_q <= wdata[MASK_BIT];
      mode_q <= tmr_mode_e'(wdata[MODE_LSB+1:MODE_LSB]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
    end else if (load) begin
      init_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_wr) begin
      div_q <= wdata[DIV_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_ENTRY) begin
      rdata[VW-1:0]              = vec_q;
      rdata[MASK_BIT]            = mask_q;
      rdata[MODE_LSB+1:MODE_LSB] = mode_q;
    end else if (addr == A_INIT) begin
      rdata = init_q;
    end else if (addr == A_CUR) begin
      rdata = cur;
    end else if (addr == A_DIV) begin
      rdata[DIV_W-1:0] = div_q;
    end
  end

  always_comb begin
    vec   = vec_q;
    mask  = mask_q;
    mode  = mode_q;
    init  = init_q;
    shift = div_shift(div_q);
  end

  // R2: bits between the vector and the mask always read zero
  always_comb begin
    if (rst_n && addr == A_ENTRY) begin
      a_r2_entry_gap: assert (rdata[MASK_BIT-1:VW] == '0);
    end
  end

endmodule

// File: rtl/loc_irq_timer.sv
module loc_irq_timer
  import lit_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector
);

  logic            rst_s;
  logic [CNT_W-1:0] cur;
  logic [CNT_W-1:0] init;
  logic            mask;
  tmr_mode_e       mode;
  logic [SH_W-1:0] shift;
  logic            load;
  logic            div_wr;
  logic            tick;
  logic            presc_clr;

  lit_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  lit_regs #(.AW(ADDR_W), .CW(CNT_W), .VW(VEC_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_s),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .cur    (cur),
    .rdata  (reg_rdata),
    .vec    (irq_vector),
    .mask   (mask),
    .mode   (mode),
    .init   (init),
    .shift  (shift),
    .load   (load),
    .div_wr (div_wr)
  );

  assign presc_clr = load || div_wr;

  lit_prescale u_presc (
    .clk   (clk),
    .rst_n (rst_s),
    .clr   (presc_clr),
    .shift (shift),
    .tick  (tick)
  );

  lit_counter #(.CW(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_s),
    .load       (load),
    .load_val   (reg_wdata),
    .reload_val (init),
    .mode       (mode),
    .mask       (mask),
    .tick       (tick),
    .cur        (cur),
    .irq        (irq_req)
  );

  // R7: a request never follows an expiry seen while masked
  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_s)
    irq_req |-> !$past(mask));

  // R5: a request is never raised by the edge that loads a new count
  a_r5_no_irq_on_load: assert property (@(posedge clk) disable iff (!rst_s)
    load |=> !irq_req);

endmodule

// File: tb/loc_irq_timer_test.sv
module loc_irq_timer_test;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_req;
  logic [7:0]  irq_vector;

  int vectors;
  int fails;
  int irq_total;
  int base;
  logic [31:0] rv;

  localparam logic [11:0] A_ENT = 12'h320;
  localparam logic [11:0] A_INI = 12'h380;
  localparam logic [11:0] A_CUR = 12'h390;
  localparam logic [11:0] A_DIV = 12'h3E0;

  loc_irq_timer uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq_req    (irq_req),
    .irq_vector (irq_vector)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (irq_req === 1'b1) irq_total <= irq_total + 1;
  end

  function automatic int div_of(input logic [3:0] code);
    case (code & 4'hB)
      4'h0: return 2;
      4'h1: return 4;
      4'h2: return 8;
      4'h3: return 16;
      4'h8: return 32;
      4'h9: return 64;
      4'hA: return 128;
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] exp_cur(input int periodic, input logic [31:0] n,
                                          input int d, input int k);
    int t;
    t = k / d;
    if (periodic != 0) return n - 32'(t % int'(n));
    if (t >= int'(n)) return 32'd0;
    return n - 32'(t);
  endfunction

  function automatic int exp_pulses(input int periodic, input int n, input int d, input int k);
    if (periodic != 0) return k / (n * d);
    return (k >= n * d) ? 1 : 0;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_edges(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic int seen();
    return irq_total - base + ((irq_req === 1'b1) ? 1 : 0);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    vectors = 0;
    fails = 0;
    irq_total = 0;
    base = 0;
    reg_wr = 1'b0;
    reg_addr = '0;
    reg_wdata = '0;
    rst_n = 1'b0;
    void'($urandom(32'd20240612));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_edges(4);

    // R1 reset state
    rd_reg(A_ENT, rv); check("R1 entry", rv, 32'h0001_0000);
    rd_reg(A_INI, rv); check("R1 init", rv, 32'h0);
    rd_reg(A_CUR, rv); check("R1 cur", rv, 32'h0);
    rd_reg(A_DIV, rv); check("R1 div", rv, 32'h0);
    check("R1 irq", 32'(irq_req), 32'h0);

    // R2 field readback
    wr_reg(A_ENT, 32'hFFFF_FFFF);
    rd_reg(A_ENT, rv); check("R2 entry fields", rv, 32'h0007_00FF);
    wr_reg(A_DIV, 32'hFFFF_FFFF);
    rd_reg(A_DIV, rv); check("R2 div field", rv, 32'h0000_000F);
    wr_reg(A_INI, 32'h1234_5678);
    rd_reg(A_INI, rv); check("R2 init readback", rv, 32'h1234_5678);
    rd_reg(12'h330, rv); check("R2 unmapped", rv, 32'h0);
    wr_reg(A_INI, 32'h0);

    // R3 every divide code, boundary either side of the third tick
    for (int c = 0; c < 16; c++) begin
      int d;
      d = div_of(4'(c));
      wr_reg(A_ENT, 32'h0001_0000);
      wr_reg(A_DIV, 32'(c));
      wr_reg(A_INI, 32'd5);
      wait_edges(3 * d - 1);
      rd_reg(A_CUR, rv); check($sformatf("R3 code %0h before", c), rv, 32'd3);
      wait_edges(1);
      rd_reg(A_CUR, rv); check($sformatf("R3 code %0h at", c), rv, 32'd2);
    end

    // R5 one-shot exact pulse position, N=3 D=2
    wr_reg(A_ENT, 32'h0000_0040);
    wr_reg(A_DIV, 32'h0);
    wr_reg(A_INI, 32'd3);
    base = irq_total;
    wait_edges(5);
    check("R5 no early irq", 32'(irq_req), 32'h0);
    wait_edges(1);
    check("R5 irq pulse", 32'(irq_req), 32'h1);
    rd_reg(A_CUR, rv); check("R5 cur zero", rv, 32'h0);
    wait_edges(1);
    check("R5 irq single", 32'(irq_req), 32'h0);
    wait_edges(13);
    rd_reg(A_CUR, rv); check("R5 stays zero", rv, 32'h0);
    check("R5 one pulse", 32'(seen()), 32'd1);

    // R6 periodic reload, N=3 D=1; R13 vector
    wr_reg(A_ENT, 32'h0002_00A5);
    wr_reg(A_DIV, 32'hB);
    wr_reg(A_INI, 32'd3);
    base = irq_total;
    wait_edges(2);
    rd_reg(A_CUR, rv); check("R6 cur before reload", rv, 32'd1);
    wait_edges(1);
    rd_reg(A_CUR, rv); check("R6 reloaded", rv, 32'd3);
    check("R6 irq at reload", 32'(irq_req), 32'h1);
    check("R13 vector", 32'(irq_vector), 32'hA5);
    wait_edges(1);
    rd_reg(A_CUR, rv); check("R6 after reload", rv, 32'd2);
    check("R6 pulse ends", 32'(irq_req), 32'h0);

    // R7 masked periodic keeps counting
    wr_reg(A_ENT, 32'h0003_0011);
    wr_reg(A_INI, 32'd4);
    base = irq_total;
    wait_edges(10);
    rd_reg(A_CUR, rv); check("R7 count runs", rv, 32'd2);
    check("R7 no irq", 32'(seen()), 32'd0);

    // R8 zero initial count stops
    wr_reg(A_ENT, 32'h0002_0000);
    wr_reg(A_INI, 32'd5);
    base = irq_total;
    wait_edges(3);
    wr_reg(A_INI, 32'd0);
    rd_reg(A_CUR, rv); check("R8 forced zero", rv, 32'h0);
    wait_edges(20);
    rd_reg(A_CUR, rv); check("R8 stays zero", rv, 32'h0);
    check("R8 no irq", 32'(seen()), 32'd0);

    // R9 full-width count
    wr_reg(A_ENT, 32'h0000_0000);
    wr_reg(A_INI, 32'hFFFF_FFFF);
    wait_edges(10);
    rd_reg(A_CUR, rv); check("R9 max count", rv, 32'hFFFF_FFF5);

    // R10 divide write restarts phase, D=4
    wr_reg(A_DIV, 32'h1);
    wr_reg(A_INI, 32'd10);
    wait_edges(3);
    wr_reg(A_DIV, 32'h1);
    rd_reg(A_CUR, rv); check("R10 no tick on write", rv, 32'd10);
    wait_edges(3);
    rd_reg(A_CUR, rv); check("R10 full period", rv, 32'd10);
    wait_edges(1);
    rd_reg(A_CUR, rv); check("R10 tick after period", rv, 32'd9);

    // R11 current-count write ignored, D=1
    wr_reg(A_DIV, 32'hB);
    wr_reg(A_INI, 32'd7);
    wait_edges(2);
    wr_reg(A_CUR, 32'h0);
    rd_reg(A_CUR, rv); check("R11 write ignored", rv, 32'd4);

    // R12 deadline and reserved modes freeze
    for (int m = 2; m < 4; m++) begin
      wr_reg(A_ENT, 32'(m) << 17);
      wr_reg(A_INI, 32'd6);
      base = irq_total;
      wait_edges(20);
      rd_reg(A_CUR, rv); check($sformatf("R12 mode %0d frozen", m), rv, 32'd6);
      check($sformatf("R12 mode %0d no irq", m), 32'(seen()), 32'd0);
    end

    // R4 R5 R6 random mix
    for (int i = 0; i < 30; i++) begin
      logic [3:0] code;
      int d, n, per, k;
      code = 4'($urandom % 16);
      d    = div_of(code);
      n    = 1 + int'($urandom % 8);
      per  = int'($urandom % 2);
      k    = int'($urandom % (2 * n * d + 4));
      wr_reg(A_ENT, (32'(per) << 17) | 32'($urandom % 256));
      wr_reg(A_DIV, 32'(code));
      wr_reg(A_INI, 32'(n));
      base = irq_total;
      wait_edges(k);
      rd_reg(A_CUR, rv);
      check($sformatf("R4 rand %0d cur", i), rv, exp_cur(per, 32'(n), d, k));
      check($sformatf("R6 rand %0d pulses", i), 32'(seen()), 32'(exp_pulses(per, n, d, k)));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule